// File: doc/BRIEF.md
# G.711 Compressor and Expander Unit

This block is the companding datapath that sits beside the primary data channel of a serial port. On the transmit side, a 32-bit two's-complement word written by the host is compressed to an 8-bit logarithmic code, either mu-law or A-law. The code is then zero-filled up to the programmed transmit word length and held in the transmit word register. On the receive side, an 8-bit code from the line is expanded to a linear sample. That sample is right-justified and sign-extended to 32 bits and held in the receive word register.

Each instance is set up either as a transmitter, which compresses, or as a receiver, which expands. With companding off, both registers pass data through unchanged. Because the result simply replaces the register contents one clock after the strobe, software can compand a value in place and read it back without shifting any serial data. The mode and word-length inputs must be held steady around a write. A write that coincides with a configuration change gives an undefined value.

Top module: `g711_compander`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tx_word` and `rx_word` become zero.
- R2: `cfg_mode` encodes 2'b00 = no companding, 2'b01 = mu-law, 2'b10 = A-law, 2'b11 = no companding. With no companding, an accepted write loads `tx_wdata` masked to its low `cfg_wlen`+1 bits into `tx_word`.
- R3: In mu-law mode, a write accepted at a clock edge loads `tx_word` at that edge. The input is read as two's complement and split into sign and magnitude. A bias of 33 is added to the magnitude. The segment s (0..7) is the position of the leading one of the biased value minus 5, and the 4 mantissa bits are the bits just below that leading one. The code is the bitwise complement of {sign (1 = negative), s[2:0], mantissa}.
- R4: In A-law mode, magnitudes below 32 use segment 0 with mantissa = magnitude[4:1]. Otherwise the segment is the leading-one position minus 4 and the mantissa is the next 4 bits below it. The code is {~sign, segment, mantissa} XOR 8'h55.
- R5: Magnitudes above 8158 (mu-law) or 4095 (A-law) are clamped to that limit. The resulting positive and negative codes are 8'h80 and 8'h00 for mu-law, and 8'hAA and 8'h2A for A-law.
- R6: With companding on, `tx_word[31:8]` is zero and the code is further masked to the low `cfg_wlen`+1 bits.
- R7: In mu-law mode, a code accepted on `rx_code` loads `rx_word` at that edge. With u = ~code, the magnitude is ((2·u[3:0]+33) << u[6:4]) − 33, negated when u[7] is 1, and the result is sign-extended to 32 bits.
- R8: In A-law mode, with v = code XOR 8'h55, the magnitude is 2·v[3:0]+1 when v[6:4] is 0. Otherwise it is (2·v[3:0]+33) << (v[6:4]−1). The value is negative when v[7] is 0 and is sign-extended to 32 bits.
- R9: With no companding, an accepted receive code loads `rx_word` as the code zero-extended to 32 bits.
- R10: A transmitter (`cfg_is_tx`=1) ignores `rx_valid`, and a receiver ignores `tx_wr`. Without an accepted strobe, each output register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Companding law select |
| cfg_is_tx | input | 1 | 1 = transmitter (compress), 0 = receiver (expand) |
| cfg_wlen | input | 5 | Transmit word length minus one |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Linear word to transmit |
| tx_word | output | 32 | Transmit register contents after companding |
| rx_valid | input | 1 | Receive code strobe |
| rx_code | input | 8 | Received 8-bit code |
| rx_word | output | 32 | Receive register contents after expansion |

## Verification
The bench first targets the segment edges, such as A-law 31 and 32 where the linear first segment ends, and the clamp points just above and below 8158 and 4095. A design with an off-by-one in the leading-one search or the clamp would return a code one segment away. It also drives the most negative 32-bit word, where a narrow magnitude path wraps and turns full-scale negative into a small code. All 256 codes of each law are expanded and compared against a reference model, which catches a missed 0x55 XOR, a wrong sign polarity or a lost sign extension. Word-length masking and the ignored strobes are checked at the output registers, so that leaking upper bits or a receiver that overwrites its transmit register would show up.

// File: rtl/g711_pkg.sv
package g711_pkg;

    typedef enum logic [1:0] {
        CMP_OFF  = 2'b00,
        CMP_MU   = 2'b01,
        CMP_ALAW = 2'b10,
        CMP_RSVD = 2'b11
    } cmp_mode_e;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    localparam int unsigned CODE_W  = 8;
    localparam int unsigned MAG_W   = 14;
    localparam int unsigned MU_CLIP = 8158;
    localparam int unsigned A_CLIP  = 4095;
    localparam logic [7:0]  A_XOR   = 8'h55;

    typedef struct packed {
        logic       neg;
        logic [2:0] seg;
        logic [3:0] mant;
    } code_t;

endpackage

// File: rtl/g711_encoder.sv
module g711_encoder
    import g711_pkg::*;
#(
    parameter law_e LAW = LAW_MU,
    parameter int   DW  = 32
) (
    input  logic [DW-1:0]     sample,
    output logic [CODE_W-1:0] code
);
    localparam int unsigned CLIP = (LAW == LAW_MU) ? MU_CLIP : A_CLIP;
    localparam logic [DW-1:0] CLIP_V = DW'(CLIP);

    logic          neg;
    logic [DW-1:0] mag;
    logic [12:0]   lim;
    code_t         fields;

    // sign/magnitude split, then clamp to the law's range
    always_comb begin
        neg = sample[DW-1];
        mag = neg ? (-sample) : sample;
        lim = (mag > CLIP_V) ? CLIP_V[12:0] : mag[12:0];
    end

    generate
        if (LAW == LAW_MU) begin : g_mu
            logic [12:0] biased;
            logic [12:0] shifted;
            always_comb begin
                biased = lim + 13'd33;
                fields.neg = neg;
                fields.seg = 3'd0;
                for (int i = 0; i < 8; i++) begin
                    if (biased[5+i]) fields.seg = 3'(i);
                end
                shifted     = biased >> ({1'b0, fields.seg} + 4'd1);
                fields.mant = shifted[3:0];
                code        = ~fields;
            end
        end else begin : g_alaw
            logic [12:0] shifted;
            always_comb begin
                fields.neg = ~neg;
                fields.seg = 3'd0;
                for (int i = 1; i < 8; i++) begin
                    if (lim[4+i]) fields.seg = 3'(i);
                end
                shifted     = (fields.seg == 3'd0) ? (lim >> 1) : (lim >> fields.seg);
                fields.mant = shifted[3:0];
                code        = fields ^ A_XOR;
            end
        end
    endgenerate

endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
    import g711_pkg::*;
#(
    parameter law_e LAW = LAW_MU,
    parameter int   DW  = 32
) (
    input  logic [CODE_W-1:0] code,
    output logic [DW-1:0]     sample
);
    code_t            fields;
    logic             neg;
    logic [MAG_W-1:0] mag;
    logic [DW-1:0]    ext;

    generate
        if (LAW == LAW_MU) begin : g_mu
            logic [MAG_W-1:0] step;
            always_comb begin
                fields = ~code;
                neg    = fields.neg;
                step   = ({9'd0, fields.mant, 1'b0} + 14'd33) << fields.seg;
                mag    = step - 14'd33;
            end
        end else begin : g_alaw
            always_comb begin
                fields = code ^ A_XOR;
                neg    = ~fields.neg;
                if (fields.seg == 3'd0)
                    mag = {9'd0, fields.mant, 1'b1};
                else
                    mag = ({9'd0, fields.mant, 1'b1} + 14'd32) << (fields.seg - 3'd1);
            end
        end
    endgenerate

    // right-justify and sign-extend
    always_comb begin
        ext    = {{(DW-MAG_W){1'b0}}, mag};
        sample = neg ? (-ext) : ext;
    end

endmodule

// File: rtl/g711_compander.sv
module g711_compander
    import g711_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_is_tx,
    input  logic [LW-1:0]     cfg_wlen,
    input  logic              tx_wr,
    input  logic [DW-1:0]     tx_wdata,
    output logic [DW-1:0]     tx_word,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_code,
    output logic [DW-1:0]     rx_word
);
    cmp_mode_e         mode;
    logic              tx_acc, rx_acc, comp_on;
    logic [CODE_W-1:0] enc_mu, enc_a;
    logic [DW-1:0]     dec_mu, dec_a;
    logic [DW-1:0]     tx_next, rx_next, wmask;
    logic [LW-1:0]     wshift;

    g711_encoder #(.LAW(LAW_MU), .DW(DW)) u_enc_mu (.sample(tx_wdata), .code(enc_mu));
    g711_encoder #(.LAW(LAW_A),  .DW(DW)) u_enc_a  (.sample(tx_wdata), .code(enc_a));
    g711_decoder #(.LAW(LAW_MU), .DW(DW)) u_dec_mu (.code(rx_code), .sample(dec_mu));
    g711_decoder #(.LAW(LAW_A),  .DW(DW)) u_dec_a  (.code(rx_code), .sample(dec_a));

    always_comb begin
        mode    = cmp_mode_e'(cfg_mode);
        comp_on = (mode == CMP_MU) || (mode == CMP_ALAW);
        tx_acc  = tx_wr && cfg_is_tx;
        rx_acc  = rx_valid && !cfg_is_tx;
        wshift  = LW'(DW - 1) - cfg_wlen;
        wmask   = {DW{1'b1}} >> wshift;
        case (mode)
            CMP_MU:   tx_next = {{(DW-CODE_W){1'b0}}, enc_mu};
            CMP_ALAW: tx_next = {{(DW-CODE_W){1'b0}}, enc_a};
            default:  tx_next = tx_wdata;
        endcase
        case (mode)
            CMP_MU:   rx_next = dec_mu;
            CMP_ALAW: rx_next = dec_a;
            default:  rx_next = {{(DW-CODE_W){1'b0}}, rx_code};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word <= '0;
            rx_word <= '0;
        end else begin
            if (tx_acc) tx_word <= tx_next & wmask;
            if (rx_acc) rx_word <= rx_next;
        end
    end

    // R10: registers move only on an accepted strobe
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(tx_wr && cfg_is_tx) |=> $stable(tx_word));
    p_rx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && !cfg_is_tx) |=> $stable(rx_word));

    // R6: a companded transmit word never carries bits above the code
    p_tx_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && cfg_is_tx && (cfg_mode == 2'b01 || cfg_mode == 2'b10))
        |=> (tx_word[DW-1:CODE_W] == '0));

    // R5: positive overrange clamps to the top code of each law
    p_mu_sat_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && cfg_is_tx && cfg_mode == 2'b01 && cfg_wlen >= LW'(7)
         && $signed(tx_wdata) > $signed(DW'(MU_CLIP)))
        |=> (tx_word[CODE_W-1:0] == 8'h80));
    p_a_sat_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && cfg_is_tx && cfg_mode == 2'b10 && cfg_wlen >= LW'(7)
         && $signed(tx_wdata) > $signed(DW'(A_CLIP)))
        |=> (tx_word[CODE_W-1:0] == 8'hAA));

    // R7/R8: expanded samples stay within 14 signed bits, fully sign-extended
    p_rx_sign_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_is_tx && (cfg_mode == 2'b01 || cfg_mode == 2'b10))
        |=> (rx_word[DW-1:MAG_W-1] == '0 || rx_word[DW-1:MAG_W-1] == '1));

    // R9: uncompanded receive data is zero-extended
    p_rx_plain_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_is_tx && (cfg_mode == 2'b00 || cfg_mode == 2'b11))
        |=> (rx_word[DW-1:CODE_W] == '0));

endmodule

// File: tb/g711_compander_tb.sv
module g711_compander_tb;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_is_tx = 1'b1;
    logic [4:0]  cfg_wlen = 5'd31;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic [31:0] tx_word;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_code = '0;
    logic [31:0] rx_word;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    g711_compander u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_is_tx(cfg_is_tx),
        .cfg_wlen(cfg_wlen), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_word(tx_word),
        .rx_valid(rx_valid), .rx_code(rx_code), .rx_word(rx_word)
    );

    // reference model, built from the requirement text
    function automatic logic [7:0] ref_mu_enc(logic [31:0] x);
        longint m; int seg; int b; logic neg;
        neg = x[31];
        m = neg ? -longint'($signed(x)) : longint'($signed(x));
        if (m > 8158) m = 8158;
        b = int'(m) + 33;
        seg = 0;
        while (seg < 7 && b >= (64 << seg)) seg++;
        return ~{neg, 3'(seg), 4'((b >> (seg + 1)) & 15)};
    endfunction

    function automatic logic [7:0] ref_a_enc(logic [31:0] x);
        longint m; int seg; int mi; logic neg;
        neg = x[31];
        m = neg ? -longint'($signed(x)) : longint'($signed(x));
        if (m > 4095) m = 4095;
        mi = int'(m);
        if (mi < 32) begin
            seg = 0;
            mi = mi >> 1;
        end else begin
            seg = 1;
            while (seg < 7 && mi >= (32 << seg)) seg++;
            mi = mi >> seg;
        end
        return {~neg, 3'(seg), 4'(mi & 15)} ^ 8'h55;
    endfunction

    function automatic logic [31:0] ref_mu_dec(logic [7:0] c);
        logic [7:0] u; int m;
        u = ~c;
        m = ((2 * int'(u[3:0]) + 33) << u[6:4]) - 33;
        return u[7] ? 32'(-m) : 32'(m);
    endfunction

    function automatic logic [31:0] ref_a_dec(logic [7:0] c);
        logic [7:0] v; int m;
        v = c ^ 8'h55;
        if (v[6:4] == 3'd0) m = 2 * int'(v[3:0]) + 1;
        else m = (2 * int'(v[3:0]) + 33) << (v[6:4] - 3'd1);
        return v[7] ? 32'(m) : 32'(-m);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic do_tx(input logic [1:0] m, input logic [4:0] wl, input logic [31:0] d);
        @(negedge clk);
        cfg_is_tx = 1'b1; cfg_mode = m; cfg_wlen = wl; tx_wdata = d; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic do_rx(input logic [1:0] m, input logic [7:0] c);
        @(negedge clk);
        cfg_is_tx = 1'b0; cfg_mode = m; rx_code = c; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // {mode, input word, expected tx_word} at full word length
    localparam int NV = 18;
    localparam logic [65:0] VEC [NV] = '{
        {2'b01, 32'd0,          32'h000000FF},
        {2'b01, 32'hFFFFFFFF,   32'h0000007E},
        {2'b01, 32'd8158,       32'h00000080},
        {2'b01, 32'd8159,       32'h00000080},
        {2'b01, 32'd100000,     32'h00000080},
        {2'b01, -32'sd100000,   32'h00000000},
        {2'b01, 32'h80000000,   32'h00000000},
        {2'b01, 32'h7FFFFFFF,   32'h00000080},
        {2'b01, 32'd30,         32'h000000F0},
        {2'b10, 32'd0,          32'h000000D5},
        {2'b10, 32'hFFFFFFFF,   32'h00000055},
        {2'b10, 32'd31,         32'h000000DA},
        {2'b10, 32'd32,         32'h000000C5},
        {2'b10, 32'd4095,       32'h000000AA},
        {2'b10, 32'd70000,      32'h000000AA},
        {2'b10, -32'sd4096,     32'h0000002A},
        {2'b10, 32'h80000000,   32'h0000002A},
        {2'b00, 32'h12345678,   32'h12345678}
    };

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_bad++;
        $display("FAIL R1: watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset tx_word", tx_word, 32'h0);
        check("R1 reset rx_word", rx_word, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            do_tx(VEC[i][65:64], 5'd31, VEC[i][63:32]);
            check("R3/R4/R5 table", tx_word, VEC[i][31:0]);
        end

        // encode sweeps against the model
        for (int x = -9000; x <= 9000; x += 37) begin
            do_tx(2'b01, 5'd31, 32'(x));
            check("R3 mu sweep", tx_word, {24'd0, ref_mu_enc(32'(x))});
            do_tx(2'b10, 5'd31, 32'(x));
            check("R4 alaw sweep", tx_word, {24'd0, ref_a_enc(32'(x))});
        end
        do_tx(2'b01, 5'd31, -32'sd8159);
        check("R5 mu neg clamp", tx_word, 32'h00000000);
        do_tx(2'b10, 5'd31, -32'sd4095);
        check("R5 alaw neg edge", tx_word, 32'h0000002A);

        // word length: R2 R6
        do_tx(2'b00, 5'd15, 32'h12345678);
        check("R2 off wlen16", tx_word, 32'h00005678);
        do_tx(2'b00, 5'd0, 32'hFFFFFFFF);
        check("R2 off wlen1", tx_word, 32'h00000001);
        do_tx(2'b11, 5'd31, 32'hCAFEBABE);
        check("R2 reserved mode", tx_word, 32'hCAFEBABE);
        do_tx(2'b01, 5'd3, 32'd0);
        check("R6 mu wlen4", tx_word, 32'h0000000F);
        do_tx(2'b10, 5'd7, 32'hFFFFFFFF);
        check("R6 alaw wlen8", tx_word, 32'h00000055);

        // full decode tables: R7 R8
        for (int c = 0; c < 256; c++) begin
            do_rx(2'b01, 8'(c));
            check("R7 mu decode", rx_word, ref_mu_dec(8'(c)));
            do_rx(2'b10, 8'(c));
            check("R8 alaw decode", rx_word, ref_a_dec(8'(c)));
        end
        do_rx(2'b01, 8'h00);
        check("R7 mu full neg", rx_word, 32'hFFFFE0A1);
        do_rx(2'b01, 8'hFF);
        check("R7 mu zero", rx_word, 32'h00000000);
        do_rx(2'b10, 8'h2A);
        check("R8 alaw full neg", rx_word, 32'hFFFFF040);
        do_rx(2'b10, 8'hD5);
        check("R8 alaw small", rx_word, 32'h00000001);

        // R9
        do_rx(2'b00, 8'h9C);
        check("R9 off rx", rx_word, 32'h0000009C);
        do_rx(2'b11, 8'hF1);
        check("R9 reserved rx", rx_word, 32'h000000F1);

        // R10: ignored strobes
        do_tx(2'b00, 5'd31, 32'hA5A5A5A5);
        do_rx(2'b00, 8'h3C);
        @(negedge clk);
        cfg_is_tx = 1'b1; cfg_mode = 2'b01; rx_code = 8'h00; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R10 tx ignores rx", rx_word, 32'h0000003C);
        @(negedge clk);
        cfg_is_tx = 1'b0; cfg_mode = 2'b00; tx_wdata = 32'h11112222; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        check("R10 rx ignores tx", tx_word, 32'hA5A5A5A5);
        repeat (4) @(negedge clk);
        check("R10 tx hold", tx_word, 32'hA5A5A5A5);
        check("R10 rx hold", rx_word, 32'h0000003C);

        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check("R1 rerun tx", tx_word, 32'h0);
        check("R1 rerun rx", rx_word, 32'h0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule